// File: doc/BRIEF.md
# Integer-N Synthesizer Divider Set with FSK Selection

This block holds the digital counters of an integer-N frequency synthesizer. On the oscillator side, a dual-modulus prescaler model divides by 65 while a swallow count is left and by 64 after that. A main count then closes one feedback cycle every 64·N + A oscillator clocks. On the crystal side, a reference counter emits one comparison pulse every M reference clocks. The synthesized frequency is therefore (f_ref / M)·(64·N + A), and the comparison rate is f_ref / M.

Two complete divider sets are stored at the inputs. A selector picks one of them from the receive/transmit state, the FSK mode field and the transmit data bit. This gives three transmit schemes:
- modulation applied outside the loop, where the dividers ignore the data;
- switching between the two sets;
- stepping the swallow count of set 1 up or down by one, which shifts the output by exactly one comparison frequency.

A new selection is only sampled when a divider finishes a cycle, so an output pulse is never shortened. A power-up sequencer lets only the reference path run at first. It raises a block enable after the second reference pulse, and the feedback divider starts once that enable reaches the oscillator domain. All pins are plain control and status signals. There is no streamed data, so the block has no handshake.

Top module: `fsk_synth_divider`

## Requirements
- R1: While running, fb_pulse is high for exactly one vco_clk cycle. Successive rising edges of fb_pulse are 64·N + A vco_clk cycles apart, where N and A are the selected main and swallow counts.
- R2: ref_pulse is high for one ref_clk cycle when the selected M is greater than 1. Successive pulses are M ref_clk cycles apart.
- R3: With tx_mode = 0 (receive), set 0 (n0, a0, m0) is used whatever the values of fsk_mode and tx_data.
- R4: With tx_mode = 1 and fsk_mode = 2'b00 or 2'b01, set 1 is used and tx_data has no effect on either period.
- R5: With tx_mode = 1 and fsk_mode = 2'b10, tx_data = 0 selects set 0 and tx_data = 1 selects set 1, for N, A and M together.
- R6: With tx_mode = 1 and fsk_mode = 2'b11, N and M come from set 1. The swallow count is a1 + 1 when tx_data = 1 and a1 − 1 when tx_data = 0.
- R7: block_en is 0 from reset until the second ref_pulse has been seen. It goes to 1 on the ref_clk edge that follows that pulse, and then stays at 1.
- R8: fb_pulse stays 0 while block_en is 0.
- R9: A change of the selected set during a feedback cycle does not alter that cycle. The new counts apply from the next cycle.
- R10: cfg_err is 1 if any of the following holds for the selection: N is 0, M is 0, the effective swallow count is not below N, or in fsk_mode 2'b11 the ±1 step leaves the 6-bit range (a1 = 63 with data 1, or a1 = 0 with data 0). Otherwise cfg_err is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Oscillator-side clock being divided |
| ref_clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| n0 | input | 12 | Main count, set 0 |
| m0 | input | 10 | Reference count, set 0 |
| a0 | input | 6 | Swallow count, set 0 |
| n1 | input | 12 | Main count, set 1 |
| m1 | input | 10 | Reference count, set 1 |
| a1 | input | 6 | Swallow count, set 1 |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| fsk_mode | input | 2 | 00/01 outside-loop modulation, 10 set switching, 11 swallow ±1 |
| tx_data | input | 1 | Transmit data bit |
| fb_pulse | output | 1 | Divided feedback pulse, vco_clk domain |
| ref_pulse | output | 1 | Divided reference pulse, ref_clk domain |
| block_en | output | 1 | Enable for the rest of the circuit after the prestart |
| cfg_err | output | 1 | Selected setting is out of range |

## Verification
A table covers every pair of transmit state and FSK mode with both data values. The two stored sets have clearly different N, A and M, and the periods of both dividers are measured for each row. This separates a wrong set choice from a wrong ±1 direction, and it also shows a data bit leaking into a mode that must ignore it. Directed cases then cover three further points:
- a data flip in the middle of a feedback cycle, to show that the old period completes;
- the reference pulse count that opens the enable;
- settings at each range limit, to exercise cfg_err.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic [1:0] {
    FSK_OUT_A = 2'b00,
    FSK_OUT_B = 2'b01,
    FSK_SWAP  = 2'b10,
    FSK_STEP  = 2'b11
  } fsk_mode_e;
endpackage

// File: rtl/sds_set_select.sv
module sds_set_select
  import sds_pkg::*;
#(
  parameter int N_W = 12,
  parameter int M_W = 10,
  parameter int A_W = 6,
  localparam int AE_W = A_W + 1
) (
  input  logic [N_W-1:0]  n0,
  input  logic [M_W-1:0]  m0,
  input  logic [A_W-1:0]  a0,
  input  logic [N_W-1:0]  n1,
  input  logic [M_W-1:0]  m1,
  input  logic [A_W-1:0]  a1,
  input  logic            tx_mode,
  input  logic [1:0]      fsk_mode,
  input  logic            tx_data,
  output logic [N_W-1:0]  n_sel,
  output logic [M_W-1:0]  m_sel,
  output logic [AE_W-1:0] a_sel,
  output logic            cfg_err
);
  logic            use_set1;
  logic            step_mode;
  logic [AE_W-1:0] a_base;
  logic            step_out;
  logic            a_too_big;

  // R3..R6: set choice
  always_comb begin
    use_set1  = 1'b0;
    step_mode = 1'b0;
    if (tx_mode) begin
      case (fsk_mode)
        FSK_SWAP: use_set1 = tx_data;
        FSK_STEP: begin
          use_set1  = 1'b1;
          step_mode = 1'b1;
        end
        default:  use_set1 = 1'b1;
      endcase
    end
  end

  always_comb begin
    n_sel  = use_set1 ? n1 : n0;
    m_sel  = use_set1 ? m1 : m0;
    a_base = {1'b0, (use_set1 ? a1 : a0)};
    if (step_mode)
      a_sel = tx_data ? a_base + AE_W'(1) : a_base - AE_W'(1);
    else
      a_sel = a_base;
  end

  // R10: range checks on the effective selection
  always_comb begin
    step_out  = step_mode && ((tx_data && (&a1)) || (!tx_data && (a1 == '0)));
    a_too_big = (N_W'(a_sel) >= n_sel);
    cfg_err   = (n_sel == '0) || (m_sel == '0) || step_out || a_too_big;
  end
endmodule

// File: rtl/sds_fb_div.sv
module sds_fb_div #(
  parameter int N_W   = 12,
  parameter int AE_W  = 7,
  parameter int PRESC = 64,
  localparam int PRE_W = $clog2(PRESC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [N_W-1:0]  n_sel,
  input  logic [AE_W-1:0] a_sel,
  output logic            fb_pulse
);
  localparam logic [PRE_W-1:0] LONG_LD  = PRE_W'(PRESC);
  localparam logic [PRE_W-1:0] SHORT_LD = PRE_W'(PRESC - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [N_W-1:0]   n_left;
  logic [AE_W-1:0]  a_left;
  logic [AE_W-1:0]  a_next;

  assign a_next = (a_left != '0) ? a_left - AE_W'(1) : '0;

  // Prescaler terminal count picks modulus 65 while swallow cycles remain.
  // New N/A values are sampled only at a cycle end (R9).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      n_left   <= '0;
      a_left   <= '0;
      fb_pulse <= 1'b0;
    end else if (!run) begin
      pre_cnt  <= '0;
      n_left   <= '0;
      a_left   <= '0;
      fb_pulse <= 1'b0;
    end else if (n_left == '0) begin
      n_left   <= n_sel;
      a_left   <= a_sel;
      pre_cnt  <= (a_sel != '0) ? LONG_LD : SHORT_LD;
      fb_pulse <= 1'b0;
    end else if (pre_cnt != '0) begin
      pre_cnt  <= pre_cnt - PRE_W'(1);
      fb_pulse <= 1'b0;
    end else if (n_left == N_W'(1)) begin
      n_left   <= n_sel;
      a_left   <= a_sel;
      pre_cnt  <= (a_sel != '0) ? LONG_LD : SHORT_LD;
      fb_pulse <= 1'b1;
    end else begin
      n_left   <= n_left - N_W'(1);
      a_left   <= a_next;
      pre_cnt  <= (a_next != '0) ? LONG_LD : SHORT_LD;
      fb_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/sds_ref_div.sv
module sds_ref_div #(
  parameter int M_W = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_sel,
  output logic           ref_pulse
);
  logic [M_W-1:0] m_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left    <= '0;
      ref_pulse <= 1'b0;
    end else if (m_left <= M_W'(1)) begin
      m_left    <= m_sel;
      ref_pulse <= (m_left == M_W'(1));
    end else begin
      m_left    <= m_left - M_W'(1);
      ref_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/sds_prestart.sv
module sds_prestart #(
  parameter int PULSES = 2,
  localparam int C_W = $clog2(PULSES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  output logic block_en
);
  logic [C_W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= '0;
      block_en <= 1'b0;
    end else if (!block_en && ref_pulse) begin
      seen <= seen + C_W'(1);
      if (seen == C_W'(PULSES - 1)) block_en <= 1'b1;
    end
  end
endmodule

// File: rtl/fsk_synth_divider.sv
module fsk_synth_divider
  import sds_pkg::*;
#(
  parameter int N_W             = 12,
  parameter int M_W             = 10,
  parameter int A_W             = 6,
  parameter int PRESC           = 64,
  parameter int PRESTART_PULSES = 2,
  parameter int SYNC_STAGES     = 2
) (
  input  logic           vco_clk,
  input  logic           ref_clk,
  input  logic           rst_n,
  input  logic [N_W-1:0] n0,
  input  logic [M_W-1:0] m0,
  input  logic [A_W-1:0] a0,
  input  logic [N_W-1:0] n1,
  input  logic [M_W-1:0] m1,
  input  logic [A_W-1:0] a1,
  input  logic           tx_mode,
  input  logic [1:0]     fsk_mode,
  input  logic           tx_data,
  output logic           fb_pulse,
  output logic           ref_pulse,
  output logic           block_en,
  output logic           cfg_err
);
  localparam int AE_W = A_W + 1;

  logic [N_W-1:0]  n_sel;
  logic [M_W-1:0]  m_sel;
  logic [AE_W-1:0] a_sel;
  logic            run_vco;

  sds_set_select #(.N_W(N_W), .M_W(M_W), .A_W(A_W)) u_sel (
    .n0(n0), .m0(m0), .a0(a0), .n1(n1), .m1(m1), .a1(a1),
    .tx_mode(tx_mode), .fsk_mode(fsk_mode), .tx_data(tx_data),
    .n_sel(n_sel), .m_sel(m_sel), .a_sel(a_sel), .cfg_err(cfg_err)
  );

  sds_ref_div #(.M_W(M_W)) u_ref (
    .clk(ref_clk), .rst_n(rst_n), .m_sel(m_sel), .ref_pulse(ref_pulse)
  );

  sds_prestart #(.PULSES(PRESTART_PULSES)) u_pre (
    .clk(ref_clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .block_en(block_en)
  );

  // Enable crosses into the oscillator domain through a flop chain.
  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      logic [SYNC_STAGES-1:0] en_q;
      always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= {en_q[SYNC_STAGES-2:0], block_en};
      end
      assign run_vco = en_q[SYNC_STAGES-1];
    end else begin : g_sync_one
      logic en_q;
      always_ff @(posedge vco_clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= block_en;
      end
      assign run_vco = en_q;
    end
  endgenerate

  sds_fb_div #(.N_W(N_W), .AE_W(AE_W), .PRESC(PRESC)) u_fb (
    .clk(vco_clk), .rst_n(rst_n), .run(run_vco),
    .n_sel(n_sel), .a_sel(a_sel), .fb_pulse(fb_pulse)
  );
endmodule

// File: rtl/fsk_synth_divider_chk.sv
module fsk_synth_divider_chk #(
  parameter int N_W = 12,
  parameter int M_W = 10,
  parameter int A_W = 6
) (
  input logic           vco_clk,
  input logic           ref_clk,
  input logic           rst_n,
  input logic [N_W-1:0] n0,
  input logic [M_W-1:0] m0,
  input logic [A_W-1:0] a0,
  input logic [M_W-1:0] m1,
  input logic           tx_mode,
  input logic           fb_pulse,
  input logic           ref_pulse,
  input logic           block_en,
  input logic           cfg_err
);
  assert_fb_single_R1: assert property (@(posedge vco_clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  assert_ref_single_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ref_pulse && (m0 > M_W'(1)) && (m1 > M_W'(1))) |=> !ref_pulse);

  assert_en_sticky_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    block_en |=> block_en);

  assert_en_cause_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(block_en) |-> $past(ref_pulse));

  assert_no_early_fb_R8: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !block_en |-> !fb_pulse);

  assert_rx_range_R10: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (!tx_mode && (N_W'(a0) >= n0)) |-> cfg_err);
endmodule

bind fsk_synth_divider fsk_synth_divider_chk #(.N_W(N_W), .M_W(M_W), .A_W(A_W)) u_chk (
  .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n),
  .n0(n0), .m0(m0), .a0(a0), .m1(m1), .tx_mode(tx_mode),
  .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .block_en(block_en), .cfg_err(cfg_err)
);

// File: tb/test_fsk_synth_divider.sv
module test_fsk_synth_divider;
  logic        vco_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        rst_n   = 1'b0;
  logic [11:0] n0, n1;
  logic [9:0]  m0, m1;
  logic [5:0]  a0, a1;
  logic        tx_mode;
  logic [1:0]  fsk_mode;
  logic        tx_data;
  logic        fb_pulse, ref_pulse, block_en, cfg_err;

  int checks = 0;
  int errors = 0;
  int early_fb = 0;
  bit done = 0;

  always #2.5 vco_clk = ~vco_clk;
  always #5   ref_clk = ~ref_clk;

  fsk_synth_divider i_fsk_synth_divider (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .n0(n0), .m0(m0), .a0(a0), .n1(n1), .m1(m1), .a1(a1),
    .tx_mode(tx_mode), .fsk_mode(fsk_mode), .tx_data(tx_data),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .block_en(block_en), .cfg_err(cfg_err)
  );

  typedef struct packed {
    logic        tx;
    logic [1:0]  mode;
    logic        data;
    logic [11:0] n0;
    logic [5:0]  a0;
    logic [9:0]  m0;
    logic [11:0] n1;
    logic [5:0]  a1;
    logic [9:0]  m1;
    logic [15:0] exp_fb;
    logic [9:0]  exp_ref;
  } vec_t;

  // set 0: 64*4+3 = 259, M 5 ; set 1: 64*16+10 = 1034, M 7
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'b00, 1'b0, 12'd4, 6'd3, 10'd5, 12'd16, 6'd10, 10'd7, 16'd259,  10'd5}, // R3
    '{1'b0, 2'b10, 1'b1, 12'd4, 6'd3, 10'd5, 12'd16, 6'd10, 10'd7, 16'd259,  10'd5}, // R3
    '{1'b0, 2'b11, 1'b1, 12'd4, 6'd3, 10'd5, 12'd16, 6'd10, 10'd7, 16'd259,  10'd5}, // R3
    '{1'b1, 2'b00, 1'b0, 12'd4, 6'd3, 10'd5, 12'd16, 6'd10, 10'd7, 16'd1034, 10'd7}, // R4
    '{1'b1, 2'b01, 1'b1, 12'd4, 6'd3, 10'd5, 12'd16, 6'd10, 10'd7, 16'd1034, 10'd7}, // R4
    '{1'b1, 2'b10, 1'b0, 12'd4, 6'd3, 10'd5, 12'd16, 6'd10, 10'd7, 16'd259,  10'd5}, // R5
    '{1'b1, 2'b10, 1'b1, 12'd4, 6'd3, 10'd5, 12'd16, 6'd10, 10'd7, 16'd1034, 10'd7}, // R5
    '{1'b1, 2'b11, 1'b1, 12'd4, 6'd3, 10'd5, 12'd16, 6'd10, 10'd7, 16'd1035, 10'd7}, // R6
    '{1'b1, 2'b11, 1'b0, 12'd4, 6'd3, 10'd5, 12'd16, 6'd10, 10'd7, 16'd1033, 10'd7}, // R6
    '{1'b1, 2'b10, 1'b1, 12'd4, 6'd3, 10'd5, 12'd2,  6'd1,  10'd3, 16'd129,  10'd3}  // R1
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    tx_mode = v.tx; fsk_mode = v.mode; tx_data = v.data;
    n0 = v.n0; a0 = v.a0; m0 = v.m0; n1 = v.n1; a1 = v.a1; m1 = v.m1;
  endtask

  task automatic wait_fb();
    @(negedge vco_clk);
    while (!fb_pulse) @(negedge vco_clk);
  endtask

  task automatic fb_period(output int p);
    wait_fb();
    p = 0;
    do begin @(negedge vco_clk); p++; end while (!fb_pulse);
  endtask

  task automatic ref_period(output int p);
    @(negedge ref_clk);
    while (!ref_pulse) @(negedge ref_clk);
    p = 0;
    do begin @(negedge ref_clk); p++; end while (!ref_pulse);
  endtask

  always @(negedge vco_clk)
    if (rst_n && fb_pulse && !block_en) early_fb++;

  initial begin
    repeat (200000) @(posedge vco_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p, seen;
    apply(VEC[0]);
    repeat (4) @(negedge vco_clk);
    // reset state
    check("R7 block_en in reset", int'(block_en), 0);
    check("R1 fb_pulse in reset", int'(fb_pulse), 0);
    check("R2 ref_pulse in reset", int'(ref_pulse), 0);
    @(negedge ref_clk);
    rst_n = 1'b1;

    // R7 prestart: enable only after the second reference pulse
    seen = 0;
    while (seen < 2) begin
      @(negedge ref_clk);
      if (block_en) check("R7 block_en before second pulse", 1, 0);
      if (ref_pulse) seen++;
    end
    check("R7 block_en at second pulse", int'(block_en), 0);
    @(negedge ref_clk);
    check("R7 block_en after second pulse", int'(block_en), 1);
    check("R2 ref_pulse width", int'(ref_pulse), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge vco_clk);
      check($sformatf("R10 cfg_err vector %0d", i), int'(cfg_err), 0);
      fb_period(p);
      check($sformatf("R1 fb period vector %0d", i), p, int'(VEC[i].exp_fb));
      ref_period(p);
      check($sformatf("R2 ref period vector %0d", i), p, int'(VEC[i].exp_ref));
    end

    // R4: data toggle in outside-loop mode leaves the period unchanged
    apply(VEC[3]);
    fb_period(p);
    tx_data = 1'b1;
    fb_period(p);
    check("R4 data ignored fb period", p, 1034);

    // R9: mid-cycle change does not touch the running cycle
    apply(VEC[5]);
    fb_period(p);
    check("R5 set0 period before change", p, 259);
    p = 0;
    repeat (20) begin @(negedge vco_clk); p++; end
    tx_data = 1'b1;
    do begin @(negedge vco_clk); p++; end while (!fb_pulse);
    check("R9 running cycle keeps old count", p, 259);
    p = 0;
    do begin @(negedge vco_clk); p++; end while (!fb_pulse);
    check("R9 next cycle uses new count", p, 1034);

    // R10 range flags
    apply(VEC[0]); a0 = 6'd4; #1;
    check("R10 a0 equal to n0", int'(cfg_err), 1);
    a0 = 6'd3; #1;
    check("R10 a0 below n0", int'(cfg_err), 0);
    apply(VEC[7]); a1 = 6'd63; n1 = 12'd100; #1;
    check("R10 step up past 63", int'(cfg_err), 1);
    apply(VEC[8]); a1 = 6'd0; #1;
    check("R10 step down past 0", int'(cfg_err), 1);
    apply(VEC[3]); m1 = 10'd0; #1;
    check("R10 M zero", int'(cfg_err), 1);
    apply(VEC[3]); n1 = 12'd0; #1;
    check("R10 N zero", int'(cfg_err), 1);
    apply(VEC[7]); n1 = 12'd11; #1;
    check("R10 stepped A reaches N", int'(cfg_err), 1);

    check("R8 fb pulses while disabled", early_fb, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule